// File: doc/BRIEF.md
# GPIO Bank with Set/Clear Control

This block is one bank of 32 general-purpose pins attached to a simple memory-mapped register bus. It keeps two per-pin state vectors: the output-data latch and the direction (output-enable) latch. Software never writes either vector directly. Each vector has its own write-only "set" and "clear" offsets, and a write changes only the pins whose data bit is 1. A single bus write can therefore raise, lower, enable or disable any group of pins, with no read-modify-write sequence and no race against other agents that own other pins of the same bank.

Two readable offsets are provided. One returns the live pin levels, taken through a two-flop synchronizer, whatever the pin's direction. The other returns the direction state. The pad ring takes `pin_out` and `pin_oe` side by side and builds the tri-state driver from them. Edge detection and interrupts are handled by a separate block that watches the same pins.

The bus is a single-cycle interface. A write is taken on the rising clock edge when `bus_en` and `bus_we` are both high. Read data is combinational and valid in the same cycle as a read request (`bus_en` high, `bus_we` low). All byte offsets are compared in full, so unaligned or unmapped addresses decode to nothing.

Top module: `gpio_bank_sc`

## Requirements
- R1: After synchronous reset (`rst_n` low at a rising edge), every pin is an input (`pin_oe` all zeros) and the output-data latch (`pin_out`) is all zeros.
- R2: A write to offset 0x18 sets to 1, after that edge, every `pin_out` bit whose write-data bit is 1. All other `pin_out` bits keep their value.
- R3: A write to offset 0x24 clears to 0, after that edge, every `pin_out` bit whose write-data bit is 1. All other `pin_out` bits keep their value.
- R4: A write to offset 0x54 sets to 1 (output) every `pin_oe` bit whose write-data bit is 1. All other `pin_oe` bits keep their value.
- R5: A write to offset 0x60 clears to 0 (input) every `pin_oe` bit whose write-data bit is 1. All other `pin_oe` bits keep their value.
- R6: A read of offset 0x00 returns `pin_in` as it was sampled two rising edges earlier. Bit n is pin n. A change at the pins is invisible after one edge and visible after the second.
- R7: A read of offset 0x0c returns the current direction vector: bit n is 1 when pin n is an output and 0 when it is an input.
- R8: A read of a write-only offset (0x18, 0x24, 0x54, 0x60) or of an unmapped offset returns zero. `bus_rdata` is zero in any cycle without a read.
- R9: Writes to the read-only offsets 0x00 and 0x0c, and to unmapped offsets, change neither `pin_out` nor `pin_oe`.
- R10: `pin_out` and `pin_oe` hold their value in every cycle that does not carry a write to one of their own set/clear offsets. Reads, idle cycles and pin activity leave both unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_en | input | 1 | Bus access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data, one bit per pin |
| bus_rdata | output | 32 | Read data, combinational, zero when not reading |
| pin_in | input | 32 | Asynchronous levels seen at the pads |
| pin_out | output | 32 | Output-data latch towards the pads |
| pin_oe | output | 32 | Per-pin output enable (1 = drive) |

## Verification
The hardest behaviour to reach from the ports is the exact latency of the level readback. It only shows if a pin change and a read fall one edge apart. So the bench changes `pin_in` on a falling edge and reads offset 0x00 on each of the next two falling edges. It expects the old value first and the new one second. A second delicate point is that a mask write must leave every unselected bit alone. To show this, walking-one and alternating patterns are written over a latch that already holds a mix of ones and zeros, and the whole 32-bit vector is compared after each write. A blind overwrite and a write that inverts the mask both show up this way.

// File: rtl/gpb_pkg.sv
// Package: shared offsets and types for the set/clear GPIO bank.
// Assumes byte offsets fit in the bus address width chosen at the top.
package gpb_pkg;

    localparam int OFS_LEVEL   = 'h00;
    localparam int OFS_DIR     = 'h0C;
    localparam int OFS_OUT_SET = 'h18;
    localparam int OFS_OUT_CLR = 'h24;
    localparam int OFS_DIR_SET = 'h54;
    localparam int OFS_DIR_CLR = 'h60;

    // One strobe per write-only offset.
    typedef struct packed {
        logic out_set;
        logic out_clr;
        logic dir_set;
        logic dir_clr;
    } gpb_wstb_t;

    // Which vector the read port returns.
    typedef enum logic [1:0] {
        RSEL_NONE  = 2'd0,
        RSEL_LEVEL = 2'd1,
        RSEL_DIR   = 2'd2
    } gpb_rsel_e;

endpackage

// File: rtl/gpb_decode.sv
// Module: address decoder. Turns one bus cycle into write strobes and a
// read selector. Assumes the full byte offset is compared; anything that
// matches no offset produces no strobe and a NONE read selection.
module gpb_decode
    import gpb_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    output gpb_wstb_t         wstb,
    output gpb_rsel_e         rsel
);

    logic wr_cyc;
    logic rd_cyc;

    assign wr_cyc = bus_en &  bus_we;
    assign rd_cyc = bus_en & ~bus_we;

    // Write strobes: only the four write-only offsets react to writes.
    always_comb begin
        wstb         = '0;
        wstb.out_set = wr_cyc && (bus_addr == ADDR_W'(OFS_OUT_SET));
        wstb.out_clr = wr_cyc && (bus_addr == ADDR_W'(OFS_OUT_CLR));
        wstb.dir_set = wr_cyc && (bus_addr == ADDR_W'(OFS_DIR_SET));
        wstb.dir_clr = wr_cyc && (bus_addr == ADDR_W'(OFS_DIR_CLR));
    end

    // Read select: only the level and direction offsets are readable.
    always_comb begin
        rsel = RSEL_NONE;
        if (rd_cyc) begin
            if (bus_addr == ADDR_W'(OFS_LEVEL)) begin
                rsel = RSEL_LEVEL;
            end else if (bus_addr == ADDR_W'(OFS_DIR)) begin
                rsel = RSEL_DIR;
            end
        end
    end

endmodule

// File: rtl/gpb_setclr_reg.sv
// Module: vector register updated only by set and clear masks.
// A 0 bit in either mask leaves that bit alone. If both masks are applied
// to the same bit in one cycle, the clear takes priority.
module gpb_setclr_reg #(
    parameter int               WIDTH     = 32,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [WIDTH-1:0] set_mask,
    input  logic             clr_en,
    input  logic [WIDTH-1:0] clr_mask,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] set_eff;
    logic [WIDTH-1:0] clr_eff;
    logic [WIDTH-1:0] q_nxt;

    // Gate each mask with its strobe.
    always_comb begin
        set_eff = set_en ? set_mask : '0;
        clr_eff = clr_en ? clr_mask : '0;
    end

    // Next state: OR in the set bits, then knock out the clear bits.
    always_comb begin
        q_nxt = (q | set_eff) & ~clr_eff;
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RESET_VAL;
        end else begin
            q <= q_nxt;
        end
    end

endmodule

// File: rtl/gpb_sync.sv
// Module: multi-stage synchronizer for asynchronous pin levels.
// Assumes STAGES >= 2. The output lags the input by STAGES clock edges.
module gpb_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] chain [STAGES];

    // First stage captures the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain[0] <= '0;
        end else begin
            chain[0] <= d;
        end
    end

    // Later stages each retime the previous one.
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain[s] <= '0;
            end else begin
                chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/gpb_rdmux.sv
// Module: read data multiplexer. Returns zero for anything that is not a
// read of a readable offset, so write-only offsets read back as zero.
module gpb_rdmux
    import gpb_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  gpb_rsel_e        rsel,
    input  logic [WIDTH-1:0] level,
    input  logic [WIDTH-1:0] dir,
    output logic [WIDTH-1:0] rdata
);

    // Choose the vector named by the decoder.
    always_comb begin
        unique case (rsel)
            RSEL_LEVEL: rdata = level;
            RSEL_DIR:   rdata = dir;
            default:    rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_bank_sc.sv
// Module: top of the set/clear GPIO bank. Holds output data and direction,
// both changed only through write-only set/clear offsets, and returns the
// synchronized pin levels and direction. Assumes single-cycle bus accesses
// and pins that are asynchronous to clk.
module gpio_bank_sc
    import gpb_pkg::*;
#(
    parameter int NUM_PINS    = 32,
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_en,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [NUM_PINS-1:0] bus_wdata,
    output logic [NUM_PINS-1:0] bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe
);

    localparam logic [NUM_PINS-1:0] OUT_RST = '0;
    localparam logic [NUM_PINS-1:0] DIR_RST = '0;

    gpb_wstb_t           wstb;
    gpb_rsel_e           rsel;
    logic [NUM_PINS-1:0] level_sync;

    gpb_decode #(
        .ADDR_W  (ADDR_W)
    ) u_decode (
        .bus_en  (bus_en),
        .bus_we  (bus_we),
        .bus_addr(bus_addr),
        .wstb    (wstb),
        .rsel    (rsel)
    );

    gpb_setclr_reg #(
        .WIDTH    (NUM_PINS),
        .RESET_VAL(OUT_RST)
    ) u_out_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (wstb.out_set),
        .set_mask(bus_wdata),
        .clr_en  (wstb.out_clr),
        .clr_mask(bus_wdata),
        .q       (pin_out)
    );

    gpb_setclr_reg #(
        .WIDTH    (NUM_PINS),
        .RESET_VAL(DIR_RST)
    ) u_dir_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (wstb.dir_set),
        .set_mask(bus_wdata),
        .clr_en  (wstb.dir_clr),
        .clr_mask(bus_wdata),
        .q       (pin_oe)
    );

    gpb_sync #(
        .WIDTH (NUM_PINS),
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (pin_in),
        .q    (level_sync)
    );

    gpb_rdmux #(
        .WIDTH(NUM_PINS)
    ) u_rdmux (
        .rsel (rsel),
        .level(level_sync),
        .dir  (pin_oe),
        .rdata(bus_rdata)
    );

endmodule

// File: rtl/gpb_checker.sv
// Module: property checker for gpio_bank_sc, attached by bind below.
// Observes only the top-level ports.
module gpb_checker #(
    parameter int NUM_PINS = 32,
    parameter int ADDR_W   = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_en,
    input logic                bus_we,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [NUM_PINS-1:0] bus_wdata,
    input logic [NUM_PINS-1:0] bus_rdata,
    input logic [NUM_PINS-1:0] pin_in,
    input logic [NUM_PINS-1:0] pin_out,
    input logic [NUM_PINS-1:0] pin_oe
);

    logic       wr;
    logic       rd;
    logic [1:0] since_rst;
    logic       wr_out;
    logic       wr_dir;
    logic       rd_wo;

    assign wr     = bus_en && bus_we;
    assign rd     = bus_en && !bus_we;
    assign wr_out = wr && (bus_addr == ADDR_W'('h18) || bus_addr == ADDR_W'('h24));
    assign wr_dir = wr && (bus_addr == ADDR_W'('h54) || bus_addr == ADDR_W'('h60));
    assign rd_wo  = rd && (bus_addr == ADDR_W'('h18) || bus_addr == ADDR_W'('h24) ||
                           bus_addr == ADDR_W'('h54) || bus_addr == ADDR_W'('h60));

    // Count edges since reset release, saturating, for the latency check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rst <= '0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    AST_OUT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == ADDR_W'('h18)) |=> ((pin_out & $past(bus_wdata)) == $past(bus_wdata))); // R2
    AST_OUT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == ADDR_W'('h24)) |=> ((pin_out & $past(bus_wdata)) == '0)); // R3
    AST_DIR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == ADDR_W'('h54)) |=> ((pin_oe & $past(bus_wdata)) == $past(bus_wdata))); // R4
    AST_DIR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == ADDR_W'('h60)) |=> ((pin_oe & $past(bus_wdata)) == '0)); // R5
    AST_LEVEL_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && bus_addr == ADDR_W'('h00) && since_rst >= 2'd2) |-> (bus_rdata == $past(pin_in, 2))); // R6
    AST_DIR_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && bus_addr == ADDR_W'('h0C)) |-> (bus_rdata == pin_oe)); // R7
    AST_WO_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_wo || !rd) |-> (bus_rdata == '0)); // R8
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !wr_out) |=> $stable(pin_out)); // R10
    AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !wr_dir) |=> $stable(pin_oe)); // R10

endmodule

bind gpio_bank_sc gpb_checker #(
    .NUM_PINS(NUM_PINS),
    .ADDR_W  (ADDR_W)
) i_gpb_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_en   (bus_en),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .pin_in   (pin_in),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe)
);

// File: tb/test_gpio_bank_sc.sv
// Bench: sweeps every pin through set/clear of data and direction, checks
// readback latency, write-only reads and ignored writes against a bench model.
module test_gpio_bank_sc;

    localparam int CLK_PERIOD = 10;
    localparam int NP         = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          bus_en;
    logic          bus_we;
    logic [7:0]    bus_addr;
    logic [NP-1:0] bus_wdata;
    logic [NP-1:0] bus_rdata;
    logic [NP-1:0] pin_in;
    logic [NP-1:0] pin_out;
    logic [NP-1:0] pin_oe;

    int            n_chk  = 0;
    int            n_fail = 0;
    logic [NP-1:0] m_out;
    logic [NP-1:0] m_oe;
    logic [NP-1:0] rd_val;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_bank_sc i_gpio_bank_sc (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_en   (bus_en),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .pin_in   (pin_in),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe)
    );

    task automatic check(input string req, input logic [NP-1:0] act, input logic [NP-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // Write on a falling edge; outputs are sampled just after the taking edge.
    task automatic bus_write(input logic [7:0] a, input logic [NP-1:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_en = 1'b0; bus_we = 1'b0; bus_wdata = '0;
    endtask

    // Read on a falling edge; combinational data sampled before the next edge.
    task automatic bus_read(input logic [7:0] a, output logic [NP-1:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_en = 1'b0;
    endtask

    task automatic wr_model(input logic [7:0] a, input logic [NP-1:0] d);
        bus_write(a, d);
        case (a)
            8'h18: m_out = m_out | d;
            8'h24: m_out = m_out & ~d;
            8'h54: m_oe  = m_oe | d;
            8'h60: m_oe  = m_oe & ~d;
            default: ;
        endcase
    endtask

    task automatic check_state(input string req);
        check(req, pin_out, m_out);
        check(req, pin_oe, m_oe);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0;
        bus_wdata = '0; pin_in = '0;
        m_out = '0; m_oe = '0;
        repeat (3) @(posedge clk);
        #1;
        check("R1", pin_out, '0);
        check("R1", pin_oe, '0);
        @(negedge clk);
        rst_n = 1'b1;
        bus_read(8'h0C, rd_val);
        check("R1", rd_val, '0);

        // R2/R3: walk each pin high then low over a background of ones and zeros.
        wr_model(8'h18, 32'hA5A5_0F0F);
        check_state("R2");
        for (int i = 0; i < NP; i++) begin
            wr_model(8'h18, NP'(1) << i);
            check_state("R2");
            wr_model(8'h24, NP'(1) << i);
            check_state("R3");
        end
        wr_model(8'h18, 32'hFFFF_FFFF);
        check_state("R2");
        wr_model(8'h24, 32'h5555_5555);
        check_state("R3");
        wr_model(8'h24, 32'h0000_0000);
        check_state("R3");

        // R4/R5/R7: walk direction bits, reading the direction back.
        wr_model(8'h54, 32'h0F0F_3C3C);
        check_state("R4");
        for (int i = 0; i < NP; i++) begin
            wr_model(8'h54, NP'(1) << i);
            check_state("R4");
            bus_read(8'h0C, rd_val);
            check("R7", rd_val, m_oe);
            wr_model(8'h60, NP'(1) << i);
            check_state("R5");
        end
        wr_model(8'h60, 32'hFFFF_0000);
        check_state("R5");
        wr_model(8'h54, 32'h8000_0001);
        bus_read(8'h0C, rd_val);
        check("R7", rd_val, m_oe);

        // R6: level appears only after the second edge.
        for (int k = 0; k < 6; k++) begin
            logic [NP-1:0] prev;
            logic [NP-1:0] nxt;
            prev = pin_in;
            nxt  = (k % 2 == 0) ? (32'h1234_5678 ^ (NP'(k) << (k * 4))) : ~prev;
            @(negedge clk);
            pin_in = nxt;
            bus_read(8'h00, rd_val);
            check("R6", rd_val, prev);
            bus_read(8'h00, rd_val);
            check("R6", rd_val, nxt);
        end

        // R8: write-only and unmapped reads are zero; idle rdata is zero.
        bus_read(8'h18, rd_val); check("R8", rd_val, '0);
        bus_read(8'h24, rd_val); check("R8", rd_val, '0);
        bus_read(8'h54, rd_val); check("R8", rd_val, '0);
        bus_read(8'h60, rd_val); check("R8", rd_val, '0);
        bus_read(8'h30, rd_val); check("R8", rd_val, '0);
        bus_read(8'h0D, rd_val); check("R8", rd_val, '0);
        @(negedge clk);
        #1;
        check("R8", bus_rdata, '0);

        // R9: writes to read-only and unmapped offsets change nothing.
        wr_model(8'h18, 32'hC3C3_C3C3);
        foreach (rd_val[j]) begin end
        begin
            logic [7:0] bad [5];
            bad = '{8'h00, 8'h0C, 8'h30, 8'h19, 8'hFC};
            foreach (bad[j]) begin
                wr_model(bad[j], 32'hFFFF_FFFF);
                check_state("R9");
                wr_model(bad[j], 32'h0000_0000);
                check_state("R9");
            end
        end

        // R10: pin activity, reads and idle cycles leave both vectors alone.
        @(negedge clk);
        pin_in = 32'hDEAD_BEEF;
        repeat (3) @(posedge clk);
        #1;
        check_state("R10");
        bus_read(8'h00, rd_val);
        bus_read(8'h0C, rd_val);
        @(posedge clk);
        #1;
        check_state("R10");

        // R1: reset in mid-run returns to the reset state.
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R1", pin_out, '0);
        check("R1", pin_oe, '0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule